// File: doc/BRIEF.md
# Stacked-Layer High-Momentum Doublet Correlator

This block pairs hits on two closely spaced sensor layers. A track with high transverse momentum crosses both layers at nearly the same column, so a hit on the partner layer together with a local hit a few columns away counts as a candidate doublet. The local layer supplies its hits as a 256-bit pattern that is held steady. The partner layer supplies one hit column per clock. For each partner column, a logarithmic shifter brings a 16-column window of the local pattern into line with that column. The window is then ANDed with a loadable enable mask and reduced by a priority encoder.

The encoder's "found" output is the accept flag. Its position, given as a signed offset from the partner column, is the track angle. A single shifter-and-encoder path serves every partner hit, so the block holds one coincidence unit in place of one per column. The enable mask sets how wide the momentum cut is. It can also be shifted off centre to correct a misalignment between the two layers.

Top module: `dblt_correlator`

## Requirements
- R1: After reset, out_valid, out_accept and out_offset are all zero, and the enable mask holds all ones (every window position enabled).
- R2: A partner hit sampled with col_valid high at clock edge E produces exactly one result with out_valid high after edge E+2. A new hit is accepted on every clock, and results appear in the order the hits arrived.
- R3: For partner column c, window position k (0 to 15) looks at local column c+k-8. The local pattern is sampled at the same edge as the column.
- R4: Window positions that map to a local column below 0 or above 255 read as empty. Nothing wraps around the pattern ends.
- R5: Mask bit k enables window position k. A local hit at a disabled position never causes an accept.
- R6: When several enabled positions match, the lowest k wins. out_offset is k-8 as 5-bit two's complement, so its range is -8 to +7.
- R7: A valid result with no enabled match has out_accept low and out_offset zero.
- R8: A mask write with mask_we high at edge E changes the mask used for hits sampled after E. A hit sampled at E itself still uses the old mask.
- R9: While out_valid is low, out_accept and out_offset are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| local_hits | input | 256 | Local-layer hit pattern, one bit per column |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_data | input | 16 | New enable mask, bit k for window position k |
| col_valid | input | 1 | A partner hit column is present |
| col_idx | input | 8 | Partner hit column |
| out_valid | output | 1 | A result is present |
| out_accept | output | 1 | Doublet accepted |
| out_offset | output | 5 | Signed track-angle offset of the winning position |

## Verification
A wrong shift stage changes the reported offset, or moves the accept to other columns, two cycles after the affected partner column arrives. Stages that are used only by high column values show up only at the upper end of the column range. A mask register that is corrupted or latched at the wrong time shows up on the first hit after the write, either as an accept at a disabled position or as a missing accept. A fault in the pipeline valid shows up as a missing or extra result, which breaks the strict one-result-per-hit ordering.

// File: rtl/dblt_pkg.sv
package dblt_pkg;
    localparam int COLS  = 256;
    localparam int COL_W = $clog2(COLS);
    localparam int WIN   = 16;
    localparam int HALF  = WIN / 2;
    localparam int IDX_W = $clog2(WIN);
    localparam int OFF_W = IDX_W + 1;
    localparam int EXT_W = COLS + WIN;

    typedef struct packed {
        logic           vld;
        logic [WIN-1:0] win;
    } stage_t;

    typedef struct packed {
        logic                    vld;
        logic                    acc;
        logic signed [OFF_W-1:0] off;
    } result_t;

    function automatic logic signed [OFF_W-1:0] idx_to_off(input logic [IDX_W-1:0] idx);
        return OFF_W'(idx) - OFF_W'(HALF);
    endfunction
endpackage

// File: rtl/dblt_log_shift.sv
module dblt_log_shift
    import dblt_pkg::*;
(
    input  logic [COLS-1:0]  pattern,
    input  logic [COL_W-1:0] amount,
    output logic [WIN-1:0]   window
);
    logic [EXT_W-1:0] stage [0:COL_W];

    assign stage[0] = {{HALF{1'b0}}, pattern, {HALF{1'b0}}};

    for (genvar s = 0; s < COL_W; s++) begin : g_stage
        assign stage[s+1] = amount[s] ? (stage[s] >> (1 << s)) : stage[s];
    end

    assign window = stage[COL_W][WIN-1:0];
endmodule

// File: rtl/dblt_prio_enc.sv
module dblt_prio_enc
    import dblt_pkg::*;
(
    input  logic [WIN-1:0]   req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIN - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dblt_mask_reg.sv
module dblt_mask_reg
    import dblt_pkg::*;
#(
    parameter logic [WIN-1:0] INIT = '1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [WIN-1:0] wdata,
    output logic [WIN-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst)     mask <= INIT;
        else if (we) mask <= wdata;
    end
endmodule

// File: rtl/dblt_correlator.sv
module dblt_correlator
    import dblt_pkg::*;
#(
    parameter logic [WIN-1:0] MASK_INIT = '1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [COLS-1:0]         local_hits,
    input  logic                    mask_we,
    input  logic [WIN-1:0]          mask_data,
    input  logic                    col_valid,
    input  logic [COL_W-1:0]        col_idx,
    output logic                    out_valid,
    output logic                    out_accept,
    output logic signed [OFF_W-1:0] out_offset
);
    logic [WIN-1:0]   mask_q;
    logic [WIN-1:0]   aligned;
    logic             enc_found;
    logic [IDX_W-1:0] enc_idx;
    stage_t           s1_q;
    result_t          res_q;

    dblt_mask_reg #(.INIT(MASK_INIT)) i_mask (
        .clk(clk), .rst(rst), .we(mask_we), .wdata(mask_data), .mask(mask_q)
    );

    dblt_log_shift i_shift (
        .pattern(local_hits), .amount(col_idx), .window(aligned)
    );

    // Stage 1: aligned, masked window (mask as held before this edge)
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld <= col_valid;
            s1_q.win <= col_valid ? (aligned & mask_q) : '0;
        end
    end

    dblt_prio_enc i_enc (
        .req(s1_q.win), .found(enc_found), .idx(enc_idx)
    );

    // Stage 2: encoded result
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.vld <= s1_q.vld;
            res_q.acc <= s1_q.vld && enc_found;
            res_q.off <= (s1_q.vld && enc_found) ? idx_to_off(enc_idx) : '0;
        end
    end

    assign out_valid  = res_q.vld;
    assign out_accept = res_q.acc;
    assign out_offset = res_q.off;
endmodule

// File: rtl/dblt_correlator_chk.sv
module dblt_correlator_chk
    import dblt_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    col_valid,
    input logic                    mask_we,
    input logic [WIN-1:0]          mask_data,
    input logic [WIN-1:0]          mask_q,
    input logic                    out_valid,
    input logic                    out_accept,
    input logic signed [OFF_W-1:0] out_offset
);
    assert_result_follows_hit_R2: assert property (@(posedge clk) disable iff (rst)
        col_valid |=> ##1 out_valid);

    assert_result_has_cause_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(col_valid, 2));

    assert_miss_zero_offset_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_accept) |-> (out_offset == '0));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_accept && out_offset == '0));

    assert_mask_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_q));

    assert_mask_loads_R8: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask_q == $past(mask_data)));
endmodule

bind dblt_correlator dblt_correlator_chk i_chk (
    .clk(clk), .rst(rst), .col_valid(col_valid), .mask_we(mask_we),
    .mask_data(mask_data), .mask_q(mask_q), .out_valid(out_valid),
    .out_accept(out_accept), .out_offset(out_offset)
);

// File: tb/test_dblt_correlator.sv
module test_dblt_correlator;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [255:0]       loc = '0;
    logic               mask_we = 1'b0;
    logic [15:0]        mask_data = '0;
    logic               col_valid = 1'b0;
    logic [7:0]         col_idx = '0;
    logic               out_valid;
    logic               out_accept;
    logic signed [4:0]  out_offset;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] model_mask = 16'hFFFF;

    typedef struct {
        bit               acc;
        logic signed [4:0] off;
        string            tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    dblt_correlator i_dblt_correlator (
        .clk(clk), .rst(rst), .local_hits(loc), .mask_we(mask_we),
        .mask_data(mask_data), .col_valid(col_valid), .col_idx(col_idx),
        .out_valid(out_valid), .out_accept(out_accept), .out_offset(out_offset)
    );

    task automatic check(input bit ok, input string tag, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    function automatic exp_t model(input logic [7:0] c, input string tag);
        exp_t e;
        e.acc = 1'b0;
        e.off = '0;
        e.tag = tag;
        for (int k = 15; k >= 0; k--) begin
            int li;
            li = int'(c) + k - 8;
            if (li >= 0 && li < 256 && loc[li] && model_mask[k]) begin
                e.acc = 1'b1;
                e.off = 5'(k - 8);
            end
        end
        return e;
    endfunction

    // Driver: call at a negedge; leaves inputs driven for the next posedge
    task automatic send(input logic [7:0] c, input string tag,
                        input bit wr = 1'b0, input logic [15:0] wd = '0);
        q.push_back(model(c, tag));
        col_valid = 1'b1;
        col_idx   = c;
        mask_we   = wr;
        mask_data = wd;
        @(negedge clk);
        if (wr) model_mask = wd;
        col_valid = 1'b0;
        mask_we   = 1'b0;
    endtask

    task automatic wmask(input logic [15:0] wd);
        mask_we   = 1'b1;
        mask_data = wd;
        @(negedge clk);
        mask_we    = 1'b0;
        model_mask = wd;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && !done) begin
                if (out_valid) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R2", $sformatf("unexpected result act_valid=1 exp_valid=0"));
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(out_accept == e.acc && out_offset == e.off, e.tag,
                              $sformatf("act acc=%0b off=%0d exp acc=%0b off=%0d",
                                        out_accept, out_offset, e.acc, e.off));
                    end
                end else begin
                    check(!out_accept && out_offset == 0, "R9",
                          $sformatf("idle act acc=%0b off=%0d exp 0/0", out_accept, out_offset));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: act=timeout exp=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset outputs
        check(!out_valid && !out_accept && out_offset == 0, "R1",
              $sformatf("act v=%0b a=%0b o=%0d exp 0/0/0", out_valid, out_accept, out_offset));
        // R1: mask reset to all ones -> lowest position wins with full pattern
        loc = '1;
        send(8'd100, "R1");
        drain();

        // R3: single hit at each window position around column 50
        for (int k = 0; k < 16; k++) begin
            loc = '0;
            loc[50 + k - 8] = 1'b1;
            send(8'd50, "R3");
        end
        // R2: back-to-back varied columns
        loc = '0;
        loc[10] = 1'b1; loc[200] = 1'b1; loc[131] = 1'b1;
        send(8'd12, "R2"); send(8'd197, "R2"); send(8'd128, "R2"); send(8'd60, "R2");
        drain();

        // R4: edges, no wrap
        loc = '0; loc[255] = 1'b1;
        send(8'd0, "R4");
        send(8'd250, "R4");
        send(8'd255, "R4");
        loc = '0; loc[0] = 1'b1;
        send(8'd255, "R4");
        send(8'd3, "R4");
        send(8'd0, "R4");
        drain();

        // R6: several matches, lowest wins
        loc = '0; loc[77] = 1'b1; loc[80] = 1'b1; loc[84] = 1'b1;
        send(8'd80, "R6");
        send(8'd84, "R6");
        send(8'd73, "R6");
        // R7: no match
        send(8'd150, "R7");
        drain();

        // R5: narrow mask hides off-centre hits
        wmask(16'h0300);
        send(8'd80, "R5");
        send(8'd77, "R5");
        send(8'd85, "R5");
        wmask(16'h0000);
        send(8'd80, "R5");
        drain();

        // R8: write coincident with a hit uses the old mask
        wmask(16'hFFFF);
        loc = '0; loc[92] = 1'b1;
        send(8'd100, "R8", 1'b1, 16'h0100);
        send(8'd100, "R8");
        send(8'd92, "R8");
        drain();

        // Random patterns and masks
        for (int n = 0; n < 400; n++) begin
            if (n % 40 == 0) begin
                loc = '0;
                for (int b = 0; b < 12; b++) loc[$urandom_range(255, 0)] = 1'b1;
            end
            if (n % 25 == 7)
                send(8'($urandom_range(255, 0)), "R5", 1'b1, 16'($urandom));
            else
                send(8'($urandom_range(255, 0)), "R3");
            if (n % 9 == 0) @(negedge clk);
        end
        wmask(16'hFFFF);
        drain();

        check(q.size() == 0, "R2",
              $sformatf("pending act=%0d exp=0", q.size()));
        done = 1'b1;
        finish_run();
    end
endmodule